// File: doc/BRIEF.md
# Serial EEPROM Page-Write Engine

This block is the storage core that sits behind a two-wire serial front-end. It holds a 512-byte array, a 16-byte page latch with a per-byte valid mask, and a 9-bit current-address counter. The front-end sends single-cycle strobes: set the address, supply a write byte, request a read byte, or signal a bus stop. The block answers reads from the current address and collects write bytes in the latch. A stop commits only the loaded bytes to the addressed page. The commit is followed by a timed write cycle, and a busy flag is raised for the whole of that cycle.

Write-protect, the rule that writes wrap inside a page while reads wrap across the whole array, and the write-cycle length (a parameter in clock cycles) all follow the behaviour of a small serial EEPROM. At most one strobe is expected per cycle. If several arrive together, stop wins over set-address, set-address over write, and write over read.

Top module: `eeprom_page_engine`

## Requirements
- R1: After reset every array byte reads 8'hFF. A read strobe returns the byte at the current 9-bit address on `rd_data`, with `rd_valid` high for one cycle, both in the cycle after the strobe. Set-address loads the counter from `addr_in`.
- R2: Each read advances the counter by one over the full 9-bit range, so address 511 is followed by address 0.
- R3: A write byte goes into the latch slot chosen by counter bits [3:0]. Only those four bits then increment, and slot 15 is followed by slot 0 of the same page.
- R4: A byte written to a slot that is already loaded in the same transaction replaces the earlier byte.
- R5: No array byte changes before a stop arrives. At commit, the page chosen by counter bits [8:4] receives only the loaded slots, and every other byte keeps its value.
- R6: A stop that arrives with at least one loaded byte raises `busy` in the next cycle. `busy` then stays high for exactly WR_CYCLES cycles.
- R7: While `busy` is high, all strobes are ignored. The counter does not move, no byte is loaded, and `rd_valid` stays low.
- R8: No write cycle starts and `busy` stays low in three cases: a stop with no loaded byte, write bytes offered while `wp` is 1 (they are not loaded), and bytes discarded by a later set-address.
- R9: After a commit, the counter points to the slot after the last written byte, wrapped within the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Write protect; 1 refuses write bytes |
| set_addr_stb | input | 1 | Load current address from `addr_in`, discard latch |
| addr_in | input | 9 | Address for set-address |
| wr_stb | input | 1 | Offer one write byte |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | Request one read byte |
| stop_stb | input | 1 | Bus stop; commits loaded bytes |
| busy | output | 1 | Internal write cycle in progress |
| rd_valid | output | 1 | `rd_data` holds a fresh read byte |
| rd_data | output | 8 | Read byte |

## Verification
The assertions check on every cycle the rules that involve only the counter, the latch mask and `busy`. These are: a read step of one with the 9-bit wrap, a write step that stays inside its page, a frozen counter and silent reads while busy, whether a stop does or does not start a cycle, and refused loads under write-protect. Only the bench scenarios can show the array contents: overwrite within a page, untouched neighbours, masked commits, that nothing lands before the stop, and the exact length of the busy window.

// File: rtl/eepg_pkg.sv
package eepg_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STOP,
        OP_SET,
        OP_WRITE,
        OP_READ
    } eepg_op_e;

    function automatic eepg_op_e pick_op(input logic stop, input logic set,
                                         input logic wr, input logic rd);
        if (stop)      return OP_STOP;
        else if (set)  return OP_SET;
        else if (wr)   return OP_WRITE;
        else if (rd)   return OP_READ;
        else           return OP_NONE;
    endfunction

endpackage

// File: rtl/eepg_page_latch.sv
module eepg_page_latch #(
    parameter int SLOT_W = 4,
    parameter int DATA_W = 8,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      load,
    input  logic [SLOT_W-1:0]         slot,
    input  logic [DATA_W-1:0]         din,
    output logic [SLOTS*DATA_W-1:0]   bytes_q,
    output logic [SLOTS-1:0]          mask_q
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = load && (slot == SLOT_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bytes_q[s*DATA_W +: DATA_W] <= '0;
                mask_q[s]                   <= 1'b0;
            end else if (clr) begin
                mask_q[s] <= 1'b0;
            end else if (hit) begin
                bytes_q[s*DATA_W +: DATA_W] <= din;
                mask_q[s]                   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/eepg_array.sv
module eepg_array #(
    parameter int ADDR_W = 9,
    parameter int SLOT_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int SLOTS  = 1 << SLOT_W,
    localparam int PAGE_W = ADDR_W - SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [PAGE_W-1:0]       page,
    input  logic [SLOTS*DATA_W-1:0] page_bytes,
    input  logic [SLOTS-1:0]        page_mask,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [DATA_W-1:0]       rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (page_mask[s]) cells[{page, SLOT_W'(s)}] <= page_bytes[s*DATA_W +: DATA_W];
            end
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_page_engine.sv
module eeprom_page_engine #(
    parameter int ADDR_W    = 9,
    parameter int SLOT_W    = 4,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic              set_addr_stb,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              stop_stb,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import eepg_pkg::*;

    localparam int SLOTS  = 1 << SLOT_W;
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int CNT_W  = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } state_t;

    state_t st_d, st_q;

    logic                    latch_clr, latch_ld, commit;
    logic [SLOTS*DATA_W-1:0] latch_bytes;
    logic [SLOTS-1:0]        latch_mask;
    logic [DATA_W-1:0]       arr_rdata;
    eepg_op_e                op;

    // Views used by the bound checker
    logic [ADDR_W-1:0]       cur_addr;
    logic [SLOTS-1:0]        ld_mask;
    assign cur_addr = st_q.addr;
    assign ld_mask  = latch_mask;

    eepg_page_latch #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (latch_clr),
        .load    (latch_ld),
        .slot    (st_q.addr[SLOT_W-1:0]),
        .din     (wr_data),
        .bytes_q (latch_bytes),
        .mask_q  (latch_mask)
    );

    eepg_array #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .page       (st_q.addr[ADDR_W-1:SLOT_W]),
        .page_bytes (latch_bytes),
        .page_mask  (latch_mask),
        .raddr      (st_q.addr),
        .rdata      (arr_rdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        latch_clr     = 1'b0;
        latch_ld      = 1'b0;
        commit        = 1'b0;
        op            = pick_op(stop_stb, set_addr_stb, wr_stb, rd_stb);

        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end else begin
            unique case (op)
                OP_STOP: begin
                    latch_clr = 1'b1;
                    if (|latch_mask) begin
                        commit    = 1'b1;
                        st_d.busy = 1'b1;
                        st_d.cnt  = CNT_W'(WR_CYCLES - 1);
                    end
                end
                OP_SET: begin
                    latch_clr = 1'b1;
                    st_d.addr = addr_in;
                end
                OP_WRITE: begin
                    if (!wp) begin
                        latch_ld  = 1'b1;
                        st_d.addr = {st_q.addr[ADDR_W-1:SLOT_W],
                                     st_q.addr[SLOT_W-1:0] + 1'b1};
                    end
                end
                OP_READ: begin
                    st_d.rd_data  = arr_rdata;
                    st_d.rd_valid = 1'b1;
                    st_d.addr     = st_q.addr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

endmodule

// File: rtl/eepg_checker.sv
module eepg_checker #(
    parameter int ADDR_W = 9,
    parameter int SLOTS  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp,
    input logic              set_addr_stb,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              stop_stb,
    input logic              busy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [SLOTS-1:0]  ld_mask
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic rd_only, wr_only;
    assign rd_only = !busy && rd_stb && !wr_stb && !set_addr_stb && !stop_stb;
    assign wr_only = !busy && wr_stb && !set_addr_stb && !stop_stb;

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1)); // R2

    AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_only && !wp) |=> (cur_addr[ADDR_W-1:SLOT_W] == $past(cur_addr[ADDR_W-1:SLOT_W])) && (ld_mask != '0)); // R3

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr)); // R7

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid); // R7

    AST_LOADED_STOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_stb && ld_mask != '0) |=> busy); // R6

    AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_stb && ld_mask == '0) |=> !busy); // R8

    AST_WP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_only && wp) |=> $stable(ld_mask)); // R8

endmodule

bind eeprom_page_engine eepg_checker #(.ADDR_W(ADDR_W), .SLOTS(1 << SLOT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp           (wp),
    .set_addr_stb (set_addr_stb),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .stop_stb     (stop_stb),
    .busy         (busy),
    .rd_valid     (rd_valid),
    .cur_addr     (cur_addr),
    .ld_mask      (ld_mask)
);

// File: tb/tb_eeprom_page_engine.sv
module tb_eeprom_page_engine;

    localparam int W = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp = 1'b0;
    logic       set_addr_stb = 1'b0;
    logic [8:0] addr_in = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic       stop_stb = 1'b0;
    logic       busy, rd_valid;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    eeprom_page_engine #(.WR_CYCLES(W)) dut (
        .clk(clk), .rst_n(rst_n), .wp(wp),
        .set_addr_stb(set_addr_stb), .addr_in(addr_in),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .stop_stb(stop_stb),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_addr(input logic [8:0] a);
        set_addr_stb = 1'b1; addr_in = a;
        @(negedge clk);
        set_addr_stb = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic [7:0] exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check(req, int'(rd_data), int'(exp));
    endtask

    // stop, then expect (or not) a write cycle and measure it
    task automatic stop_and_wait(input string req, input bit expect_busy);
        int len;
        stop_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0;
        check({req, " busy after stop"}, int'(busy), int'(expect_busy));
        len = 0;
        while (busy && len < 10*W) begin
            len++;
            @(negedge clk);
        end
        if (expect_busy) check("R6 busy length", len, W);
    endtask

    task automatic t_reset;
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset rd_valid", int'(rd_valid), 0);
        set_addr(9'h000);
        rd_expect("R1 erased byte 000", 8'hFF);
        rd_expect("R2 next address 001", 8'hFF);
    endtask

    task automatic t_byte_write;
        set_addr(9'h1A5);
        wr_byte(8'h5A);
        stop_and_wait("R6", 1'b1);
        set_addr(9'h1A4);
        rd_expect("R5 neighbour below", 8'hFF);
        rd_expect("R1 written byte", 8'h5A);
        rd_expect("R5 neighbour above", 8'hFF);
    endtask

    task automatic t_page_wrap;
        set_addr(9'h03E);
        wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
        // counter now at 0x032; array still erased before the stop
        rd_expect("R5 before stop", 8'hFF);
        stop_and_wait("R6", 1'b1);
        set_addr(9'h03E);
        rd_expect("R3 slot E", 8'h11);
        rd_expect("R3 slot F", 8'h22);
        rd_expect("R3 next page untouched", 8'hFF);
        set_addr(9'h030);
        rd_expect("R3 wrapped slot 0", 8'h33);
        rd_expect("R3 wrapped slot 1", 8'h44);
    endtask

    task automatic t_overwrite;
        set_addr(9'h100);
        for (int i = 0; i < 17; i++) wr_byte(8'(8'h80 + i));
        stop_and_wait("R6", 1'b1);
        set_addr(9'h100);
        rd_expect("R4 slot 0 overwritten", 8'h90);
        for (int i = 1; i < 16; i++) rd_expect("R4 page byte", 8'(8'h80 + i));
    endtask

    task automatic t_counter_after_write;
        set_addr(9'h070);
        wr_byte(8'h77);
        stop_and_wait("R6", 1'b1);
        set_addr(9'h07D);
        wr_byte(8'hA1); wr_byte(8'hA2); wr_byte(8'hA3);
        stop_and_wait("R6", 1'b1);
        rd_expect("R9 counter wrapped to page start", 8'h77);
    endtask

    task automatic t_no_cycle;
        wp = 1'b1;
        set_addr(9'h0A0);
        wr_byte(8'h12);
        wp = 1'b0;
        stop_and_wait("R8 wp stop", 1'b0);
        set_addr(9'h0A0);
        rd_expect("R8 wp byte not stored", 8'hFF);
        set_addr(9'h0A8);
        stop_and_wait("R8 empty stop", 1'b0);
        set_addr(9'h0B0);
        wr_byte(8'h55);
        set_addr(9'h0C0);
        stop_and_wait("R8 discarded stop", 1'b0);
        set_addr(9'h0B0);
        rd_expect("R8 discarded byte", 8'hFF);
    endtask

    task automatic t_busy_ignore;
        int seen;
        set_addr(9'h150);
        wr_byte(8'hAB); wr_byte(8'hCD);
        stop_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0;
        seen = 0;
        set_addr(9'h1A5);
        wr_byte(8'hEE);
        rd_stb = 1'b1;
        @(negedge clk);
        if (rd_valid) seen++;
        rd_stb = 1'b0;
        @(negedge clk);
        if (rd_valid) seen++;
        check("R7 no read while busy", seen, 0);
        for (int i = 0; i < 10*W && busy; i++) @(negedge clk);
        check("R7 busy ended", int'(busy), 0);
        rd_expect("R7 counter unmoved", 8'hFF);
        set_addr(9'h150);
        rd_expect("R7 first byte", 8'hAB);
        rd_expect("R7 second byte", 8'hCD);
        rd_expect("R7 ignored write absent", 8'hFF);
    endtask

    task automatic t_read_wrap;
        set_addr(9'h1FE);
        wr_byte(8'h61); wr_byte(8'h62);
        stop_and_wait("R6", 1'b1);
        set_addr(9'h1FE);
        rd_expect("R2 addr 1FE", 8'h61);
        rd_expect("R2 addr 1FF", 8'h62);
        rd_expect("R2 wrapped to 000", 8'hFF);
        rd_expect("R2 continues at 001", 8'hFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_page_wrap();
        t_overwrite();
        t_counter_after_write();
        t_no_cycle();
        t_busy_ignore();
        t_read_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule